// File: doc/BRIEF.md
# Interrupt-Interface System Register Trap Decoder

This block settles what happens when software touches a system register of the interrupt interface. For each request it takes these inputs:

- the register's five-field encoding and whether the access is a write;
- the current exception level;
- the three nested-virtualisation control bits;
- the register-interface enable bit of EL2 and of EL3;
- the feature flag and the existence flags of EL2 and EL3;
- four trap controls taken from the hypervisor interrupt control register;
- a class tag that says which group the register belongs to.

From these it yields a single outcome: proceed, undefined, trap to EL2, trap to EL3, or redirect to memory. The access itself is carried out elsewhere.

Two kinds of register are told apart. The hypervisor interrupt control register itself is recognised by its encoding and follows an ordered chain. That chain checks the feature, then the exception level, then the virtualisation pattern or the enable bit. Every other encoding is treated as an ordinary interface register, gated at EL1 by the per-group trap controls. The decision is combinational and is captured in output registers, so the answer appears one clock after the request strobe.

Top module: `sysreg_trap_decoder`

## Requirements
- R1: The control register is recognised only by op0=3, op1=4, CRn=12, CRm=11, op2=0, for reads and writes alike. Any other encoding follows the interface-register rules, even when it differs in a single field.
- R2: An access is undefined in two cases: when `feat_present` is 0, and, for the control register only, when both `has_el2` and `has_el3` are 0.
- R3: An access from EL0 is undefined, for the control register and for interface registers.
- R4: At EL1, the control register follows this order, with `nv_ctl` written as [2:0]. If `nv_ctl[2]` and `nv_ctl[0]` are both 1, the access is redirected to memory. Otherwise, if `nv_ctl[0]` is 1, it traps to EL2. Otherwise it is undefined. `nv_ctl[1]` has no effect.
- R5: At EL2 the control register traps to EL2 when `sre_el2` is 0 and proceeds when it is 1. At EL3 the same rule uses `sre_el3` and traps to EL3.
- R6: At EL1, an interface register traps to EL2 in two cases: `trap_sel[2]` is set and the class is group 1 (code 1), or `trap_sel[1]` is set and the class is group 0 (code 0). A group trap bit has no effect on the other group.
- R7: At EL1, when `trap_sel[0]` is set, an interface register of class common (code 2) or deactivate (code 3) traps to EL2.
- R8: At EL1, when `trap_sel[3]` is set, a write to a register of class deactivate (code 3) traps to EL2. A read of that class is not affected, and neither is a write of another class.
- R9: At EL2 and EL3, an interface register proceeds whatever the trap controls hold.
- R10: `rsp_outcome` codes are 0 proceed, 1 undefined, 2 trap to EL2, 3 trap to EL3, 4 memory redirect. `rsp_ec` is 0x18 for either trap and 0 otherwise. `rsp_offset` is 0x4C0 for a redirect and 0 otherwise.
- R11: Timing. `rsp_valid` is `req_valid` delayed by one clock. The other outputs take the decision for a request on the clock after it and hold between requests. Reset clears all outputs to 0.
- R12: When several trap controls apply to one EL1 access, the result is a single trap to EL2. An undefined result from R2 or R3 takes priority over every trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| cur_el | input | 2 | Current exception level |
| nv_ctl | input | 3 | Nested-virtualisation control bits |
| sre_el2 | input | 1 | Register-interface enable of EL2 |
| sre_el3 | input | 1 | Register-interface enable of EL3 |
| feat_present | input | 1 | Interrupt-interface feature present |
| has_el2 | input | 1 | EL2 implemented |
| has_el3 | input | 1 | EL3 implemented |
| trap_sel | input | 4 | [0] common, [1] group 0, [2] group 1, [3] deactivate-write |
| reg_class | input | 2 | 0 group 0, 1 group 1, 2 common, 3 deactivate |
| rsp_valid | output | 1 | Outcome valid, one clock after request |
| rsp_outcome | output | 3 | Outcome code |
| rsp_ec | output | 6 | Syndrome class for traps |
| rsp_offset | output | 12 | Memory offset for redirects |

## Verification
Several properties are checked on every cycle:

- the outcome code is always legal;
- the syndrome class appears exactly when the outcome is a trap;
- the offset appears exactly when the outcome is a redirect;
- an EL0 or feature-absent request always comes back undefined;
- a trap to EL3 or a redirect always comes from the matching level;
- the valid strobe follows the request by one clock.

The ordering within the decision chain can only be shown by the bench's scenarios against its reference model. This covers the virtualisation patterns, the enable bits, near-miss encodings, reads against writes of the deactivate class, and overlapping trap controls.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;

  typedef enum logic [2:0] {
    OC_PROCEED = 3'd0,
    OC_UNDEF   = 3'd1,
    OC_TRAP2   = 3'd2,
    OC_TRAP3   = 3'd3,
    OC_REDIR   = 3'd4
  } outcome_e;

  typedef enum logic [1:0] {
    CLS_GRP0   = 2'd0,
    CLS_GRP1   = 2'd1,
    CLS_COMMON = 2'd2,
    CLS_DEACT  = 2'd3
  } reg_class_e;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysreg_enc_t;

  localparam int TSEL_W      = 4;
  localparam int TSEL_COMMON = 0;
  localparam int TSEL_GRP0   = 1;
  localparam int TSEL_GRP1   = 2;
  localparam int TSEL_DEACT  = 3;

endpackage

// File: rtl/sysreg_enc_match.sv
module sysreg_enc_match
  import sysreg_trap_pkg::*;
#(
  parameter logic [1:0] M_OP0 = 2'd3,
  parameter logic [2:0] M_OP1 = 3'd4,
  parameter logic [3:0] M_CRN = 4'd12,
  parameter logic [3:0] M_CRM = 4'd11,
  parameter logic [2:0] M_OP2 = 3'd0
) (
  input  sysreg_enc_t enc,
  output logic        hit
);
  localparam sysreg_enc_t MATCH = '{op0: M_OP0, op1: M_OP1, crn: M_CRN,
                                    crm: M_CRM, op2: M_OP2};

  assign hit = (enc == MATCH);
endmodule

// File: rtl/ctl_access_resolve.sv
module ctl_access_resolve
  import sysreg_trap_pkg::*;
(
  input  logic [1:0] cur_el,
  input  logic [2:0] nv_ctl,
  input  logic       sre_el2,
  input  logic       sre_el3,
  input  logic       feat_present,
  input  logic       has_el2,
  input  logic       has_el3,
  output outcome_e   ctl_out
);
  localparam logic [2:0] NV_REDIR_MASK = 3'b101;
  localparam logic [2:0] NV_TRAP_MASK  = 3'b001;

  logic nv_redir, nv_trap;
  assign nv_redir = ((nv_ctl & NV_REDIR_MASK) == NV_REDIR_MASK);
  assign nv_trap  = ((nv_ctl & NV_TRAP_MASK) == NV_TRAP_MASK);

  always_comb begin
    ctl_out = OC_UNDEF;
    if (feat_present && (has_el2 || has_el3)) begin
      case (cur_el)
        2'd0: ctl_out = OC_UNDEF;
        2'd1: begin
          if (nv_redir)     ctl_out = OC_REDIR;
          else if (nv_trap) ctl_out = OC_TRAP2;
          else              ctl_out = OC_UNDEF;
        end
        2'd2:    ctl_out = sre_el2 ? OC_PROCEED : OC_TRAP2;
        default: ctl_out = sre_el3 ? OC_PROCEED : OC_TRAP3;
      endcase
    end
  end
endmodule

// File: rtl/el1_trap_eval.sv
module el1_trap_eval
  import sysreg_trap_pkg::*;
#(
  parameter bit HAS_DEACT_TRAP = 1'b1
) (
  input  logic [TSEL_W-1:0] trap_sel,
  input  reg_class_e        reg_class,
  input  logic              is_write,
  output logic              hit
);
  logic grp_hit, common_hit, deact_hit;

  assign grp_hit = (trap_sel[TSEL_GRP1] && reg_class == CLS_GRP1) ||
                   (trap_sel[TSEL_GRP0] && reg_class == CLS_GRP0);
  assign common_hit = trap_sel[TSEL_COMMON] &&
                      (reg_class == CLS_COMMON || reg_class == CLS_DEACT);

  generate
    if (HAS_DEACT_TRAP) begin : g_deact
      assign deact_hit = trap_sel[TSEL_DEACT] && is_write &&
                         (reg_class == CLS_DEACT);
    end else begin : g_no_deact
      assign deact_hit = 1'b0;
    end
  endgenerate

  assign hit = grp_hit | common_hit | deact_hit;
endmodule

// File: rtl/sysreg_trap_decoder.sv
module sysreg_trap_decoder
  import sysreg_trap_pkg::*;
#(
  parameter int                  OFFSET_W       = 12,
  parameter int                  EC_W           = 6,
  parameter logic [OFFSET_W-1:0] REDIR_OFFSET   = 12'h4C0,
  parameter logic [EC_W-1:0]     TRAP_EC        = 6'h18,
  parameter bit                  HAS_DEACT_TRAP = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [1:0]          req_op0,
  input  logic [2:0]          req_op1,
  input  logic [3:0]          req_crn,
  input  logic [3:0]          req_crm,
  input  logic [2:0]          req_op2,
  input  logic                req_write,
  input  logic [1:0]          cur_el,
  input  logic [2:0]          nv_ctl,
  input  logic                sre_el2,
  input  logic                sre_el3,
  input  logic                feat_present,
  input  logic                has_el2,
  input  logic                has_el3,
  input  logic [TSEL_W-1:0]   trap_sel,
  input  logic [1:0]          reg_class,
  output logic                rsp_valid,
  output logic [2:0]          rsp_outcome,
  output logic [EC_W-1:0]     rsp_ec,
  output logic [OFFSET_W-1:0] rsp_offset
);
  sysreg_enc_t enc;
  logic        is_ctl;
  outcome_e    ctl_out;
  logic        el1_hit;
  outcome_e    dec;
  outcome_e    out_q;

  assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn,
                 crm: req_crm, op2: req_op2};

  sysreg_enc_match u_match (
    .enc (enc),
    .hit (is_ctl)
  );

  ctl_access_resolve u_ctl (
    .cur_el       (cur_el),
    .nv_ctl       (nv_ctl),
    .sre_el2      (sre_el2),
    .sre_el3      (sre_el3),
    .feat_present (feat_present),
    .has_el2      (has_el2),
    .has_el3      (has_el3),
    .ctl_out      (ctl_out)
  );

  el1_trap_eval #(.HAS_DEACT_TRAP(HAS_DEACT_TRAP)) u_el1 (
    .trap_sel  (trap_sel),
    .reg_class (reg_class_e'(reg_class)),
    .is_write  (req_write),
    .hit       (el1_hit)
  );

  always_comb begin
    if (is_ctl) begin
      dec = ctl_out;
    end else if (!feat_present) begin
      dec = OC_UNDEF;
    end else begin
      case (cur_el)
        2'd0:    dec = OC_UNDEF;
        2'd1:    dec = el1_hit ? OC_TRAP2 : OC_PROCEED;
        default: dec = OC_PROCEED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      out_q      <= OC_PROCEED;
      rsp_ec     <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        out_q      <= dec;
        rsp_ec     <= (dec == OC_TRAP2 || dec == OC_TRAP3) ? TRAP_EC : '0;
        rsp_offset <= (dec == OC_REDIR) ? REDIR_OFFSET : '0;
      end
    end
  end

  assign rsp_outcome = out_q;
endmodule

// File: rtl/sysreg_trap_decoder_chk.sv
module sysreg_trap_decoder_chk #(
  parameter int                  OFFSET_W = 12,
  parameter int                  EC_W     = 6,
  parameter logic [OFFSET_W-1:0] OFF_VAL  = 12'h4C0,
  parameter logic [EC_W-1:0]     EC_VAL   = 6'h18
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic [1:0]          cur_el,
  input logic                feat_present,
  input logic                rsp_valid,
  input logic [2:0]          rsp_outcome,
  input logic [EC_W-1:0]     rsp_ec,
  input logic [OFFSET_W-1:0] rsp_offset
);
  p_legal_code_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_outcome <= 3'd4));

  p_ec_on_trap_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_outcome == 3'd2 || rsp_outcome == 3'd3) == (rsp_ec == EC_VAL));

  p_ec_clear_r10: assert property (@(posedge clk) disable iff (rst)
    !(rsp_outcome == 3'd2 || rsp_outcome == 3'd3) |-> (rsp_ec == '0));

  p_offset_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_outcome == 3'd4) ? (rsp_offset == OFF_VAL) : (rsp_offset == '0));

  p_el0_undef_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(cur_el) == 2'd0) |-> (rsp_outcome == 3'd1));

  p_nofeat_undef_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(feat_present)) |-> (rsp_outcome == 3'd1));

  p_trap3_from_el3_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_outcome == 3'd3) |-> ($past(cur_el) == 2'd3));

  p_redir_from_el1_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_outcome == 3'd4) |-> ($past(cur_el) == 2'd1));

  p_strobe_delay_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || (rsp_valid == $past(req_valid)));
endmodule

bind sysreg_trap_decoder sysreg_trap_decoder_chk #(
  .OFFSET_W (OFFSET_W),
  .EC_W     (EC_W),
  .OFF_VAL  (REDIR_OFFSET),
  .EC_VAL   (TRAP_EC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .cur_el       (cur_el),
  .feat_present (feat_present),
  .rsp_valid    (rsp_valid),
  .rsp_outcome  (rsp_outcome),
  .rsp_ec       (rsp_ec),
  .rsp_offset   (rsp_offset)
);

// File: tb/sysreg_trap_decoder_test.sv
module sysreg_trap_decoder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op0 = '0;
  logic [2:0]  req_op1 = '0;
  logic [3:0]  req_crn = '0;
  logic [3:0]  req_crm = '0;
  logic [2:0]  req_op2 = '0;
  logic        req_write = 1'b0;
  logic [1:0]  cur_el = '0;
  logic [2:0]  nv_ctl = '0;
  logic        sre_el2 = 1'b0, sre_el3 = 1'b0;
  logic        feat_present = 1'b0, has_el2 = 1'b0, has_el3 = 1'b0;
  logic [3:0]  trap_sel = '0;
  logic [1:0]  reg_class = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_outcome;
  logic [5:0]  rsp_ec;
  logic [11:0] rsp_offset;

  sysreg_trap_decoder uut (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
    .req_crm(req_crm), .req_op2(req_op2), .req_write(req_write),
    .cur_el(cur_el), .nv_ctl(nv_ctl), .sre_el2(sre_el2), .sre_el3(sre_el3),
    .feat_present(feat_present), .has_el2(has_el2), .has_el3(has_el3),
    .trap_sel(trap_sel), .reg_class(reg_class),
    .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
    .rsp_ec(rsp_ec), .rsp_offset(rsp_offset)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Reference model, written from the requirements
  int    m_oc;
  string m_tag;
  task automatic model(output int oc, output string tag);
    bit ctl;
    int n;
    ctl = (req_op0 == 2'd3) && (req_op1 == 3'd4) && (req_crn == 4'd12) &&
          (req_crm == 4'd11) && (req_op2 == 3'd0);
    if (!feat_present) begin oc = 1; tag = "R2"; end
    else if (ctl && !has_el2 && !has_el3) begin oc = 1; tag = "R2"; end
    else if (cur_el == 0) begin oc = 1; tag = "R3"; end
    else if (ctl) begin
      tag = (cur_el == 1) ? "R4" : "R5";
      if (cur_el == 1) oc = (nv_ctl[2] && nv_ctl[0]) ? 4 : (nv_ctl[0] ? 2 : 1);
      else if (cur_el == 2) oc = sre_el2 ? 0 : 2;
      else oc = sre_el3 ? 0 : 3;
    end else if (cur_el >= 2) begin oc = 0; tag = "R9"; end
    else begin
      n = 0;
      if (trap_sel[2] && reg_class == 2'd1) n++;
      if (trap_sel[1] && reg_class == 2'd0) n++;
      if (trap_sel[0] && reg_class >= 2'd2) n++;
      if (trap_sel[3] && req_write && reg_class == 2'd3) n++;
      oc = (n > 0) ? 2 : 0;
      if (n > 1) tag = "R12";
      else if (n == 0) tag = "R1";
      else if (reg_class <= 2'd1) tag = "R6";
      else if (trap_sel[0]) tag = "R7";
      else tag = "R8";
    end
  endtask

  logic        exp_valid;
  int          exp_oc;
  logic [5:0]  exp_ec;
  logic [11:0] exp_off;
  string       exp_tag;

  always @(posedge clk) begin
    if (rst) begin
      exp_valid <= 1'b0; exp_oc <= 0; exp_ec <= '0; exp_off <= '0;
      exp_tag <= "R11";
    end else begin
      exp_valid <= req_valid;
      if (req_valid) begin
        model(m_oc, m_tag);
        exp_oc  <= m_oc;
        exp_ec  <= (m_oc == 2 || m_oc == 3) ? 6'h18 : 6'h00;
        exp_off <= (m_oc == 4) ? 12'h4C0 : 12'h000;
        exp_tag <= m_tag;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rsp_valid !== exp_valid || int'(rsp_outcome) != exp_oc ||
          rsp_ec !== exp_ec || rsp_offset !== exp_off) begin
        errors++;
        $display("FAIL %s (R10/R11 fields) t=%0t: actual v=%0d oc=%0d ec=%0h off=%0h expected v=%0d oc=%0d ec=%0h off=%0h",
                 exp_tag, $time, rsp_valid, rsp_outcome, rsp_ec, rsp_offset,
                 exp_valid, exp_oc, exp_ec, exp_off);
      end
    end
  end

  // enc: 0 control register, 1 op2 near miss, 2 CRm near miss, 3 other
  task automatic set_enc(input int e);
    req_op0 = 2'd3; req_op1 = 3'd4; req_crn = 4'd12; req_crm = 4'd11; req_op2 = 3'd0;
    if (e == 1) req_op2 = 3'd1;
    else if (e == 2) req_crm = 4'd12;
    else if (e == 3) begin req_op1 = 3'd0; req_crm = 4'd8; end
  endtask

  task automatic issue(input int e, input logic [1:0] el, input logic [2:0] nv,
                       input logic s2, input logic s3, input logic f,
                       input logic h2, input logic h3, input logic [1:0] cls,
                       input logic wr, input logic [3:0] ts);
    set_enc(e);
    cur_el = el; nv_ctl = nv; sre_el2 = s2; sre_el3 = s3;
    feat_present = f; has_el2 = h2; has_el3 = h3;
    reg_class = cls; req_write = wr; trap_sel = ts;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // scramble inputs while idle: outputs must hold (R11)
    cur_el = ~el; feat_present = ~f; trap_sel = ~ts;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);   // reset state checked by comparator (R11)
    rst = 1'b0;
    @(negedge clk);
    // R2: feature absent, and no EL2/EL3
    issue(0, 2'd2, 3'b000, 1, 1, 0, 1, 1, 2'd0, 0, 4'h0);
    issue(0, 2'd2, 3'b000, 1, 1, 1, 0, 0, 2'd0, 0, 4'h0);
    issue(3, 2'd1, 3'b000, 1, 1, 0, 1, 1, 2'd1, 0, 4'hF);   // R12 undef over trap
    // R3: EL0
    issue(0, 2'd0, 3'b101, 1, 1, 1, 1, 1, 2'd0, 1, 4'h0);
    issue(3, 2'd0, 3'b000, 1, 1, 1, 1, 1, 2'd1, 0, 4'hF);
    // R4: EL1 virtualisation patterns
    issue(0, 2'd1, 3'b101, 1, 1, 1, 1, 1, 2'd0, 0, 4'h0);
    issue(0, 2'd1, 3'b111, 1, 1, 1, 1, 0, 2'd0, 1, 4'h0);
    issue(0, 2'd1, 3'b001, 1, 1, 1, 1, 1, 2'd0, 0, 4'h0);
    issue(0, 2'd1, 3'b011, 1, 1, 1, 1, 1, 2'd0, 1, 4'h0);
    issue(0, 2'd1, 3'b100, 1, 1, 1, 1, 1, 2'd0, 0, 4'h0);
    issue(0, 2'd1, 3'b110, 1, 1, 1, 1, 1, 2'd0, 0, 4'h0);
    // R5: enable bits at EL2 and EL3
    issue(0, 2'd2, 3'b000, 0, 1, 1, 1, 1, 2'd0, 0, 4'h0);
    issue(0, 2'd2, 3'b000, 1, 0, 1, 1, 1, 2'd0, 1, 4'h0);
    issue(0, 2'd3, 3'b000, 1, 0, 1, 0, 1, 2'd0, 0, 4'h0);
    issue(0, 2'd3, 3'b000, 0, 1, 1, 1, 1, 2'd0, 1, 4'h0);
    // R1: near-miss encodings take the interface path
    issue(1, 2'd2, 3'b000, 0, 1, 1, 1, 1, 2'd0, 0, 4'h0);
    issue(2, 2'd1, 3'b101, 1, 1, 1, 1, 1, 2'd0, 0, 4'h0);
    // R6: group traps
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd1, 0, 4'b0100);
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd0, 0, 4'b0100);
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd0, 1, 4'b0010);
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd1, 1, 4'b0010);
    // R7: common trap covers common and deactivate classes
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd2, 0, 4'b0001);
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd3, 0, 4'b0001);
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd0, 0, 4'b0001);
    // R8: deactivate-write trap
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd3, 1, 4'b1000);
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd3, 0, 4'b1000);
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd2, 1, 4'b1000);
    // R9: upper levels ignore trap controls
    issue(3, 2'd2, 3'b000, 0, 0, 1, 1, 1, 2'd1, 1, 4'hF);
    issue(3, 2'd3, 3'b000, 0, 0, 1, 1, 1, 2'd3, 1, 4'hF);
    // R12: overlapping trap controls
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd3, 1, 4'b1001);
    issue(3, 2'd1, 3'b000, 1, 1, 1, 1, 1, 2'd1, 0, 4'hF);
    // Random traffic, back-to-back requests included (all requirements)
    for (int i = 0; i < 4000; i++) begin
      set_enc($urandom_range(0, 3));
      cur_el = 2'($urandom); nv_ctl = 3'($urandom);
      sre_el2 = 1'($urandom); sre_el3 = 1'($urandom);
      feat_present = ($urandom_range(0, 7) != 0);
      has_el2 = 1'($urandom); has_el3 = 1'($urandom);
      reg_class = 2'($urandom); req_write = 1'($urandom);
      trap_sel = 4'($urandom);
      req_valid = ($urandom_range(0, 9) < 7);
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule